// File: doc/BRIEF.md
# Four-Lane Table-Driven CRC-32 Engine

This engine produces the reflected CRC-32 of a byte stream (reversed generator 0xEDB88320) and accepts one 32-bit word per clock. For each word it XORs the word into the running remainder and cuts the result into four bytes. Each byte addresses its own 256-entry constant table. The next remainder is the XOR of the four table outputs. All four tables are computed by a constant function during elaboration, so no memory image or external file is needed.

A message that is not a whole number of words is completed through a byte port. One byte is folded in per cycle through the single-byte table. A caller pulses `start_i` to open a message. It then streams words, followed by up to three tail bytes, and marks the final data cycle with `last_i`. One cycle later `done_o` pulses and `crc_o` shows the bit-inverted remainder, which is the value appended to the message. `crc_o` keeps that value until the next `last_i`.

Top module: `crc32_slice4`

## Requirements
- R1: After reset `crc_o` is 0 and `done_o` is 0, and the remainder is all ones. A `last_i` pulse with no data and no `start_i` then yields `crc_o` = 0x00000000.
- R2: A cycle with `word_vld_i` high folds all four bytes of `word_i` into the remainder. Bits [7:0] are the earliest message byte and bits [31:24] the latest. `word_vld_i` and `byte_vld_i` are never high in the same cycle.
- R3: A cycle with `byte_vld_i` high folds the single message byte `byte_i` into the remainder.
- R4: `start_i` reloads the remainder with all ones. A strobe in the same cycle as `start_i` is folded into the fresh all-ones value, and any partly processed message is discarded.
- R5: The cycle after `last_i` is high, `done_o` is 1 and `crc_o` equals the inverse of the remainder, including any data strobed in the `last_i` cycle. In every other cycle `done_o` is 0.
- R6: `crc_o` keeps its value in every cycle that does not follow a `last_i` cycle.
- R7: A cycle with no strobe and no `start_i` leaves the remainder unchanged, so idle gaps inside a message do not change its CRC.
- R8: For every length from 0 to 64 bytes, the result equals the bit-serial reflected CRC-32 with all-ones initial value and inverted output. This holds whether the message is sent as words plus tail bytes or as bytes only. The message "123456789" gives 0xCBF43926.
- R9: An empty message (`start_i` and `last_i` together, no strobe) gives `crc_o` = 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Reload the remainder with all ones for a new message |
| word_vld_i | input | 1 | `word_i` carries four message bytes this cycle |
| word_i | input | 8*LANES | Message word, earliest byte in bits [7:0] |
| byte_vld_i | input | 1 | `byte_i` carries one message byte this cycle |
| byte_i | input | 8 | Message tail byte |
| last_i | input | 1 | Final cycle of the message; result is latched |
| crc_o | output | 32 | Inverted remainder captured at the last `last_i` |
| done_o | output | 1 | One-cycle pulse after `last_i` |

## Verification
The bench builds the engine with its defaults: four lanes and the reversed generator 0xEDB88320. With these values the four-table word step, the single-table tail step and every word/tail split are all exercised. Random messages of every length from 0 to 64 bytes are sent twice, once as words plus tail bytes and once as bytes only. This covers tails of zero to three bytes and checks that byte lanes are taken in the right order. A short table of well-known check strings pins the result to absolute values, not just to agreement with the serial model.

// File: rtl/crc32_slice4.sv
module crc32_slice4 #(
  parameter logic [31:0] POLY  = 32'hEDB88320,
  parameter logic [31:0] INIT  = 32'hFFFFFFFF,
  parameter int          LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               word_vld_i,
  input  logic [8*LANES-1:0] word_i,
  input  logic               byte_vld_i,
  input  logic [7:0]         byte_i,
  input  logic               last_i,
  output logic [31:0]        crc_o,
  output logic               done_o
);

  localparam int DW    = 8 * LANES;
  localparam int DEPTH = 256;

  // entry for lane l: index byte followed by l zero bytes
  function automatic logic [31:0] tbl_entry(input int lane, input int idx);
    logic [31:0] t;
    t = 32'(idx);
    for (int s = 0; s < 8 * (lane + 1); s++)
      t = t[0] ? ((t >> 1) ^ POLY) : (t >> 1);
    return t;
  endfunction

  logic [31:0] rom [LANES][DEPTH];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign rom[l][i] = tbl_entry(l, i);
    end
  end

  logic [31:0] rem_q, crc_q;
  logic        done_q;
  logic [31:0] base, mix, word_nxt, byte_nxt, rem_d;

  assign base = start_i ? INIT : rem_q;
  assign mix  = base ^ 32'(word_i);

  always_comb begin
    word_nxt = (DW < 32) ? (base >> DW) : 32'h0;
    for (int k = 0; k < LANES; k++)
      word_nxt ^= rom[LANES-1-k][mix[8*k +: 8]];
  end

  assign byte_nxt = (base >> 8) ^ rom[0][base[7:0] ^ byte_i];

  assign rem_d = word_vld_i ? word_nxt :
                 byte_vld_i ? byte_nxt : base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= INIT;
      crc_q  <= 32'h0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      done_q <= last_i;
      if (last_i) crc_q <= ~rem_d;
    end
  end

  assign crc_o  = crc_q;
  assign done_o = done_q;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_vld_i && byte_vld_i)); // R2
  AST_START_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !word_vld_i && !byte_vld_i |=> rem_q == INIT); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i && !word_vld_i && !byte_vld_i |=> $stable(rem_q)); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_i |=> done_o); // R5
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !last_i |=> !done_o); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !last_i |=> $stable(crc_o)); // R6
  AST_EMPTY_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && last_i && !word_vld_i && !byte_vld_i |=> crc_o == 32'h0); // R9

endmodule

// File: tb/crc32_slice4_tb.sv
`timescale 1ns/1ps
module crc32_slice4_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, word_vld_i = 1'b0, byte_vld_i = 1'b0, last_i = 1'b0;
  logic [31:0] word_i = '0;
  logic [7:0]  byte_i = '0;
  logic [31:0] crc_o;
  logic        done_o;

  always #2 clk = ~clk;

  crc32_slice4 dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .word_vld_i(word_vld_i), .word_i(word_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .last_i(last_i), .crc_o(crc_o), .done_o(done_o)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] msg [64];

  localparam int NV = 4;
  localparam logic [71:0] V_MSG [NV] = '{72'h0, 72'("a"), 72'("abc"), 72'("123456789")};
  localparam int          V_LEN [NV] = '{0, 1, 3, 9};
  localparam logic [31:0] V_EXP [NV] = '{32'h00000000, 32'hE8B7BE43, 32'h352441C2, 32'hCBF43926};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int len);
    logic [31:0] r = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++)
      for (int j = 0; j < 8; j++) begin
        logic fb;
        fb = r[0] ^ msg[i][j];
        r  = (r >> 1) ^ (fb ? 32'hEDB88320 : 32'h0);
      end
    return ~r;
  endfunction

  task automatic idle();
    start_i = 0; word_vld_i = 0; byte_vld_i = 0; last_i = 0;
  endtask

  // called at a negedge; returns at the negedge where the result is visible
  task automatic run_msg(input int len, input bit bytes_only, input bit fused,
                         output logic [31:0] got, output logic dn);
    int pos = 0;
    bit first = 1;
    if (!fused) begin
      start_i = 1; @(negedge clk); idle();
    end
    if (len == 0) begin
      start_i = fused; last_i = 1; @(negedge clk); idle();
    end
    while (pos < len) begin
      start_i = fused && first;
      first = 0;
      if (!bytes_only && len - pos >= 4) begin
        word_vld_i = 1;
        word_i = {msg[pos+3], msg[pos+2], msg[pos+1], msg[pos]};
        pos += 4;
      end else begin
        byte_vld_i = 1;
        byte_i = msg[pos];
        pos += 1;
      end
      last_i = (pos == len);
      @(negedge clk);
      idle();
    end
    got = crc_o;
    dn  = done_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] got;
    logic dn;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 crc after reset", crc_o, 32'h0);
    chk("R1 done after reset", {31'b0, done_o}, 32'h0);
    last_i = 1; @(negedge clk); idle();
    chk("R1 remainder all ones after reset", crc_o, 32'h0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < V_LEN[v]; i++) msg[i] = V_MSG[v][8*(V_LEN[v]-1-i) +: 8];
      run_msg(V_LEN[v], 0, v[0], got, dn);
      chk(v == 0 ? "R9 empty message" : "R8 known vector word path", got, V_EXP[v]);
      run_msg(V_LEN[v], 1, 0, got, dn);
      chk("R3 known vector byte path", got, V_EXP[v]);
    end

    // random lengths 0..64, both paths
    for (int len = 0; len <= 64; len++) begin
      for (int i = 0; i < len; i++) msg[i] = 8'($urandom);
      run_msg(len, 0, len[0], got, dn);
      chk("R2 R8 words plus tail", got, ref_crc(len));
      chk("R5 done after last", {31'b0, dn}, 32'h1);
      run_msg(len, 1, !len[0], got, dn);
      chk("R3 R8 bytes only", got, ref_crc(len));
    end

    // R7: idle gaps inside a message
    for (int i = 0; i < 9; i++) msg[i] = 8'(8'h31 + i);
    start_i = 1; @(negedge clk); idle();
    word_vld_i = 1; word_i = {msg[3], msg[2], msg[1], msg[0]}; @(negedge clk); idle();
    repeat (3) @(negedge clk);
    word_vld_i = 1; word_i = {msg[7], msg[6], msg[5], msg[4]}; @(negedge clk); idle();
    repeat (2) @(negedge clk);
    byte_vld_i = 1; byte_i = msg[8]; last_i = 1; @(negedge clk); idle();
    chk("R7 idle gaps", crc_o, 32'hCBF43926);

    // R4: restart abandons partial message; start fused with data
    start_i = 1; word_vld_i = 1; word_i = 32'hDEADBEEF; @(negedge clk); idle();
    byte_vld_i = 1; byte_i = 8'h55; @(negedge clk); idle();
    start_i = 1; word_vld_i = 1; word_i = {msg[3], msg[2], msg[1], msg[0]}; @(negedge clk); idle();
    word_vld_i = 1; word_i = {msg[7], msg[6], msg[5], msg[4]}; @(negedge clk); idle();
    byte_vld_i = 1; byte_i = msg[8]; last_i = 1; @(negedge clk); idle();
    chk("R4 restart mid message", crc_o, 32'hCBF43926);
    chk("R5 done pulse high", {31'b0, done_o}, 32'h1);

    // R6 / R5: result holds, done drops, while new data flows
    @(negedge clk);
    chk("R5 done pulse one cycle", {31'b0, done_o}, 32'h0);
    start_i = 1; word_vld_i = 1; word_i = 32'h01020304; @(negedge clk); idle();
    byte_vld_i = 1; byte_i = 8'hA5; @(negedge clk); idle();
    chk("R6 result held", crc_o, 32'hCBF43926);
    chk("R6 done stays low", {31'b0, done_o}, 32'h0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule